// File: doc/BRIEF.md
# Serial Port Modem Handshake and Loopback Section

This block holds the modem control register and modem status register of a 16550-style serial port. It drives the four active-low handshake outputs, watches the four active-low handshake inputs, tracks changes on them in sticky delta bits, and raises a modem-status interrupt request while any delta is pending and the interrupt is enabled. It also decides where the serial bit streams go. In normal mode the transmitter stream goes to the external serial output and the external serial input goes to the receiver.

Setting the loopback bit turns the block into a self-test path. The external control outputs go to their inactive high level and the external serial output rests at mark. The transmitter stream is fed straight back to the receiver. The four status inputs, and the interrupts that come from changes on them, are then taken from the low four control bits instead of the pins. The enable for the modem-status interrupt still applies. Receiver and transmitter interrupts live outside this block and carry on unchanged.

Register access is through a one-bit address (0 = control, 1 = status), a write strobe and a read strobe. Read data is registered and valid in the cycle after the read strobe.

Top module: `mdm_ctl_loop`

## Requirements
- R1: After reset all four control pins and the serial output are high, the interrupt request is low, and both registers read 0x00.
- R2: In normal mode the control pins take the inverse of control bits one cycle after the register updates, with the bit mapping bit0 = DTR, bit1 = RTS, bit2 = OUT1, bit3 = OUT2. Bit4 selects loopback.
- R3: While loopback is set, all four control pins are driven high whatever bits 0 to 3 hold.
- R4: With loopback set, the receiver input follows the transmitter stream one cycle later and the serial output stays at 1. In normal mode the receiver input follows the external serial input one cycle later, and the serial output follows the transmitter stream one cycle later.
- R5: With loopback set, status bits 4..7 (CTS, DSR, RI, DCD) equal control bits RTS, DTR, OUT1, OUT2, and changes on the external status inputs have no effect.
- R6: In normal mode status bits 4..7 are the inverted external inputs cts_n, dsr_n, ri_n, dcd_n after a synchronizer of SYNC_STAGES flops.
- R7: Status delta bit0 (CTS), bit1 (DSR) and bit3 (DCD) are set on any change of the matching status value. They stay set until the status register is read.
- R8: Status bit2 is set only when RI goes from active (1) to inactive (0).
- R9: A status register read returns the pending deltas and clears them.
- R10: The interrupt request is high one cycle after any delta bit is set while msi_en is high, and is low one cycle after msi_en is low.
- R11: Control bits 5 to 7 always read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 selects control, 1 selects status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring indicator input, active low |
| dcd_n | input | 1 | Carrier detect input, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| tx_sout | input | 1 | Serial stream from the transmitter |
| sout | output | 1 | External serial output |
| sin | input | 1 | External serial input |
| rx_sin | output | 1 | Serial stream to the receiver |
| irq_msr | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that addr names only the two registers and that the serial and enable inputs are sampled at clock edges. No constraint on the asynchronous handshake pins is needed, because those properties only look at loopback routing and gating. The stimulus changes every input half a cycle away from the active edge. It holds each handshake pattern for more than SYNC_STAGES plus two cycles before it reads status, so each captured change produces exactly one delta event. In the control-register sweep the external pins stay inactive, so status changes come only from loopback entry, exit and control writes.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned LINES   = 4;

  // control register bit positions (decoded by software)
  localparam int unsigned C_DTR   = 0;
  localparam int unsigned C_RTS   = 1;
  localparam int unsigned C_OUT1  = 2;
  localparam int unsigned C_OUT2  = 3;
  localparam int unsigned C_LOOP  = 4;

  // status line order inside the block: [0]=CTS [1]=DSR [2]=RI [3]=DCD
  localparam int unsigned S_CTS   = 0;
  localparam int unsigned S_DSR   = 1;
  localparam int unsigned S_RI    = 2;
  localparam int unsigned S_DCD   = 3;

  // only the low five control bits hold state
  localparam logic [REG_W-1:0] CTL_MASK = 8'h1F;

  // delta bits that fire on the falling (active to inactive) edge only
  localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_STS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        chain[s] <= {WIDTH{RST_V}};
      else if (s == 0)
        chain[s] <= d;
      else
        chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status #(
  parameter int unsigned          W     = 4,
  parameter logic [W-1:0]         TRAIL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sel,
  input  logic         clr,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] delta_q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic hit;
    if (TRAIL[i]) begin : g_trail
      assign hit = stat_q[i] & ~sel[i];
    end else begin : g_any
      assign hit = stat_q[i] ^ sel[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q[i]  <= 1'b0;
        delta_q[i] <= 1'b0;
      end else begin
        stat_q[i]  <= sel[i];
        // a new event on the clearing read cycle is kept
        delta_q[i] <= hit | (delta_q[i] & ~clr);
      end
    end
  end
endmodule

// File: rtl/mdm_route.sv
module mdm_route #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loop,
  input  logic [LINES-1:0] ctl,
  input  logic             tx_sout,
  input  logic             sin,
  output logic [LINES-1:0] ctl_n_q,
  output logic             sout_q,
  output logic             rx_sin_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_n_q  <= '1;
      sout_q   <= 1'b1;
      rx_sin_q <= 1'b1;
    end else begin
      ctl_n_q  <= loop ? '1 : ~ctl;
      sout_q   <= loop ? 1'b1 : tx_sout;
      rx_sin_q <= loop ? tx_sout : sin;
    end
  end
endmodule

// File: rtl/mdm_ctl_loop.sv
module mdm_ctl_loop
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       msi_en,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  input  logic       tx_sout,
  output logic       sout,
  input  logic       sin,
  output logic       rx_sin,
  output logic       irq_msr
);
  reg_sel_e         sel_reg;
  logic [REG_W-1:0] ctl_q;
  logic             loop_q;
  logic [LINES-1:0] pin_raw, pin_s, line_sel, stat_q, delta_q, ctl_n_q;
  logic             sts_rd;
  logic [REG_W-1:0] rdata_q;
  logic             irq_q;

  assign sel_reg = reg_sel_e'(addr);
  assign sts_rd  = rd_en && (sel_reg == SEL_STS);
  assign loop_q  = ctl_q[C_LOOP];

  // control register: bits above the mask never hold a one
  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (wr_en && sel_reg == SEL_CTL)
      ctl_q <= wdata & CTL_MASK;
  end

  // handshake input synchronizer, reset to the inactive level
  assign pin_raw = {dcd_n, ri_n, dsr_n, cts_n};

  mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_s)
  );

  // status source: loopback feeds the control bits back in
  always_comb begin
    if (loop_q) begin
      line_sel[S_CTS] = ctl_q[C_RTS];
      line_sel[S_DSR] = ctl_q[C_DTR];
      line_sel[S_RI]  = ctl_q[C_OUT1];
      line_sel[S_DCD] = ctl_q[C_OUT2];
    end else begin
      line_sel = ~pin_s;
    end
  end

  mdm_status #(.W(LINES), .TRAIL(TRAIL_ONLY)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .sel     (line_sel),
    .clr     (sts_rd),
    .stat_q  (stat_q),
    .delta_q (delta_q)
  );

  mdm_route #(.LINES(LINES)) u_route (
    .clk      (clk),
    .rst      (rst),
    .loop     (loop_q),
    .ctl      (ctl_q[LINES-1:0]),
    .tx_sout  (tx_sout),
    .sin      (sin),
    .ctl_n_q  (ctl_n_q),
    .sout_q   (sout),
    .rx_sin_q (rx_sin)
  );

  assign dtr_n  = ctl_n_q[C_DTR];
  assign rts_n  = ctl_n_q[C_RTS];
  assign out1_n = ctl_n_q[C_OUT1];
  assign out2_n = ctl_n_q[C_OUT2];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en)
        rdata_q <= (sel_reg == SEL_STS) ? {stat_q, delta_q} : ctl_q;
      irq_q <= msi_en & (|delta_q);
    end
  end

  assign rdata   = rdata_q;
  assign irq_msr = irq_q;
endmodule

// File: rtl/mdm_ctl_loop_chk.sv
module mdm_ctl_loop_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] rdata,
  input logic       msi_en,
  input logic       loop_q,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       tx_sout,
  input logic       sout,
  input logic       rx_sin,
  input logic       irq_msr
);
  // R3
  loop_pins_high_chk: assert property (@(posedge clk) disable iff (rst)
    loop_q |=> (dtr_n && rts_n && out1_n && out2_n));

  // R4
  loop_rx_echo_chk: assert property (@(posedge clk) disable iff (rst)
    loop_q |=> (rx_sin == $past(tx_sout)));

  // R4
  loop_sout_mark_chk: assert property (@(posedge clk) disable iff (rst)
    loop_q |=> sout);

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !msi_en |=> !irq_msr);

  // R11
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> (rdata[7:5] == 3'b000));
endmodule

bind mdm_ctl_loop mdm_ctl_loop_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .msi_en  (msi_en),
  .loop_q  (loop_q),
  .dtr_n   (dtr_n),
  .rts_n   (rts_n),
  .out1_n  (out1_n),
  .out2_n  (out2_n),
  .tx_sout (tx_sout),
  .sout    (sout),
  .rx_sin  (rx_sin),
  .irq_msr (irq_msr)
);

// File: tb/mdm_ctl_loop_tb.sv
module mdm_ctl_loop_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       msi_en = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       dtr_n, rts_n, out1_n, out2_n;
  logic       tx_sout = 1'b1, sin = 1'b1;
  logic       sout, rx_sin, irq_msr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mdm_ctl_loop #(.SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .tx_sout(tx_sout), .sout(sout), .sin(sin), .rx_sin(rx_sin),
    .irq_msr(irq_msr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // status in line order [0]=CTS [1]=DSR [2]=RI [3]=DCD
  function automatic logic [3:0] exp_stat(input logic [7:0] c, input logic [3:0] p);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return ~p;
  endfunction

  function automatic logic [3:0] exp_delta(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] x;
    x = o ^ n;
    x[2] = o[2] & ~n[2];
    return x;
  endfunction

  function automatic logic [3:0] pins();
    return {dcd_n, ri_n, dsr_n, cts_n};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [3:0] st, nst, dl;
    logic [7:0] cur;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 pins", {4'h0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    chk("R1 sout", {7'h0, sout}, 8'h01);
    chk("R1 irq", {7'h0, irq_msr}, 8'h00);
    rd(1'b0, r); chk("R1 ctl read", r, 8'h00);
    rd(1'b1, r); chk("R1 sts read", r, 8'h00);

    // sweep every control byte with the handshake pins inactive
    st = 4'h0;
    cur = 8'h00;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      logic lp;
      vb = 8'(v);
      lp = vb[4];
      msi_en = ~vb[5];
      tx_sout = vb[6];
      sin = vb[7];
      wr(1'b0, vb);
      cur = vb & 8'h1F;
      nst = exp_stat(cur, 4'hF);
      dl = exp_delta(st, nst);
      idle(3);
      if (lp) begin
        chk("R3 pins in loopback", {4'h0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
        chk("R4 loop rx", {7'h0, rx_sin}, {7'h0, vb[6]});
        chk("R4 loop sout", {7'h0, sout}, 8'h01);
      end else begin
        chk("R2 pins", {4'h0, out2_n, out1_n, rts_n, dtr_n}, {4'h0, ~vb[3:0]});
        chk("R4 normal rx", {7'h0, rx_sin}, {7'h0, vb[7]});
        chk("R4 normal sout", {7'h0, sout}, {7'h0, vb[6]});
      end
      chk("R10 irq", {7'h0, irq_msr}, {7'h0, msi_en & (|dl)});
      rd(1'b0, r); chk("R11 ctl readback", r, cur);
      rd(1'b1, r); chk("R5 R7 R8 sts", r, {nst, dl});
      rd(1'b1, r); chk("R9 deltas cleared", r, {nst, 4'h0});
      idle(2);
      chk("R10 irq after clear", {7'h0, irq_msr}, 8'h00);
      st = nst;
    end

    // R5: loopback ignores the external handshake pins
    wr(1'b0, 8'h15);
    cur = 8'h15;
    idle(3);
    rd(1'b1, r); rd(1'b1, r);
    st = exp_stat(cur, 4'hF);
    chk("R5 loop status", r, {st, 4'h0});
    {dcd_n, ri_n, dsr_n, cts_n} = 4'h0;
    idle(6);
    rd(1'b1, r); chk("R5 pins ignored", r, {st, 4'h0});
    {dcd_n, ri_n, dsr_n, cts_n} = 4'hF;
    idle(6);
    rd(1'b1, r); chk("R5 pins ignored again", r, {st, 4'h0});

    // normal mode: sweep handshake pin patterns
    wr(1'b0, 8'h00);
    idle(4);
    rd(1'b1, r); rd(1'b1, r);
    st = exp_stat(8'h00, pins());
    chk("R6 base", r, {st, 4'h0});
    msi_en = 1'b1;
    for (int k = 0; k < 48; k++) begin
      logic [3:0] p;
      p = 4'((k * 7 + 3) ^ (k >> 2));
      {dcd_n, ri_n, dsr_n, cts_n} = p;
      nst = exp_stat(8'h00, p);
      dl = exp_delta(st, nst);
      idle(6);
      chk("R10 irq ext", {7'h0, irq_msr}, {7'h0, |dl});
      rd(1'b1, r); chk("R6 R7 R8 ext sts", r, {nst, dl});
      rd(1'b1, r); chk("R9 ext clear", r, {nst, 4'h0});
      st = nst;
    end

    // R8: RI rising gives no delta, falling does
    {dcd_n, ri_n, dsr_n, cts_n} = 4'hF; idle(6); rd(1'b1, r); rd(1'b1, r);
    ri_n = 1'b0; idle(6); rd(1'b1, r);
    chk("R8 RI going active", r, 8'h40);
    ri_n = 1'b1; idle(6); rd(1'b1, r);
    chk("R8 RI going inactive", r, 8'h04);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule